// File: doc/BRIEF.md
# Power Domain Sequencer

This block turns individual power domains of a chip on and off without software walking the steps itself. Software presents a small domain number together with an on or off command. The sequencer looks up which remote power-control bus and which device on that bus serve the domain. It then reads the device's per-zone control words over a simple request/acknowledge access port, changes the request and enable bits, and writes the words back. The same port also carries the capability word, which tells the sequencer how many zones a device has.

There are two kinds of domain. A single-zone domain only ever touches zone 0. A whole-device domain reads the zone count first and powers up every zone in order. When switching the whole device off, it drops zone 0 alone to a bare power-down request. Before writing, the sequencer checks the remote side's read-only status bits and skips any write whose target state has already been reached.

Bus and device selection, byte order and error handling are all handled in the block. A configuration input selects a byte-swapped (big-endian) view of the remote words. A bus error ends the sequence at once. Each request ends with a one-cycle done pulse, and the error flag is valid in that same cycle.

Top module: `pwr_dom_seq`

## Requirements
- R1: After reset, busy, done, err and acc_req are all 0.
- R2: The lookup maps domain 1 to window 0x20 / device 14, domain 2 to window 0x20 / device 15, domain 3 to window 0x00 / device 2, and domain 4 to window 0x20 / device 17. Once acc_req is raised, the access fields stay stable until acc_ack.
- R3: Zone power-on reads the zone control word. If bit 26 is set, no write is issued. Otherwise the sequencer writes back the word read, with bit 9 cleared and bits 8, 10, 11 and 12 set.
- R4: Single-zone power-off (domains 1 to 3) reads zone 0 and always writes it back with bit 9 set and bit 10 cleared.
- R5: Whole-device power-off (domain 4) reads zone 0. If bit 25 is set, no write is issued. Otherwise the sequencer writes 0x0000_0200.
- R6: Whole-device power-on reads the capability word at offset 0x04. It then applies R3 to zones 0 to N-1 in ascending order, at offset 0x40 + 0x10·zone, where N is bits 7:0 of the capability word. If N is 0, no zone is accessed.
- R7: When big_endian is 1, read data is byte-reversed before use and write data is byte-reversed before it is driven.
- R8: A request for an unknown domain (0, 5, 6 or 7) raises done and err in the cycle after acceptance and makes no access.
- R9: An access that returns acc_err ends the sequence: no further access is made, and done is raised together with err. err is never high without done.
- R10: busy is high from the cycle after a request is accepted until done. Requests presented while busy are ignored.
- R11: done is a single-cycle pulse. It follows the cycle in which the final acknowledge arrives, and it comes with err low on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| big_endian | input | 1 | 1: remote words are byte-reversed |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_on | input | 1 | 1 = power on, 0 = power off |
| req_dom | input | DOM_W | Domain number |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with done |
| acc_req | output | 1 | Access request, held until acc_ack |
| acc_we | output | 1 | 1 = write access |
| acc_win | output | 8 | Bus window base (bus × 0x20) |
| acc_dev | output | 8 | Device number on the bus |
| acc_off | output | OFF_W | Register offset in the device |
| acc_wdata | output | 32 | Write data |
| acc_ack | input | 1 | Access complete |
| acc_rdata | input | 32 | Read data, valid with acc_ack |
| acc_err | input | 1 | Access failed, valid with acc_ack |

## Verification
An unknown domain yields done and err one cycle after the accepting edge, so the bench samples at the next falling edge and also confirms that no access was counted. Each access completes on acc_ack; the next access, or done, appears after the edge that samples that acknowledge. The bench does not assume a fixed total length for a sequence. It polls done at falling edges under a bound, then compares the remote model's stored words, the number of reads and writes, and the offset log against values derived from the requirements. Byte swapping is exercised by a model that stores logical words and reverses them on the wire, so a missing swap corrupts the zone count or the written word.

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq #(
  parameter int DOM_W = 3,
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             big_endian,
  input  logic             req_valid,
  input  logic             req_on,
  input  logic [DOM_W-1:0] req_dom,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             acc_req,
  output logic             acc_we,
  output logic [7:0]       acc_win,
  output logic [7:0]       acc_dev,
  output logic [OFF_W-1:0] acc_off,
  output logic [31:0]      acc_wdata,
  input  logic             acc_ack,
  input  logic [31:0]      acc_rdata,
  input  logic             acc_err
);
  localparam int B_GATE = 8;
  localparam int B_DN   = 9;
  localparam int B_UP   = 10;
  localparam int B_MEM  = 11;
  localparam int B_RST  = 12;
  localparam int B_OFFS = 25;
  localparam int B_ONS  = 26;
  localparam logic [OFF_W-1:0] CAP_OFF  = OFF_W'(4);
  localparam logic [OFF_W-1:0] ZONE_OFF = OFF_W'(64);
  localparam logic [31:0] ON_SET = (32'd1 << B_GATE) | (32'd1 << B_UP) |
                                   (32'd1 << B_MEM) | (32'd1 << B_RST);

  typedef enum logic [1:0] {S_IDLE, S_CAP, S_RD, S_WR} st_t;
  st_t st;

  logic        on_q, whole_q, done_q, err_q;
  logic [7:0]  win_q, dev_q, zone_q, nz_q;
  logic [31:0] word_q;

  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  logic       known, l_whole;
  logic [7:0] l_win, l_dev;
  always_comb begin
    known = 1'b1; l_whole = 1'b0; l_win = 8'h20; l_dev = 8'd0;
    case (req_dom)
      DOM_W'(1): l_dev = 8'd14;
      DOM_W'(2): l_dev = 8'd15;
      DOM_W'(3): begin l_dev = 8'd2; l_win = 8'h00; end
      DOM_W'(4): begin l_dev = 8'd17; l_whole = 1'b1; end
      default:   known = 1'b0;
    endcase
  end

  wire [31:0] rd    = big_endian ? swap32(acc_rdata) : acc_rdata;
  wire [8:0]  znext = {1'b0, zone_q} + 9'd1;
  wire        zlast = znext >= {1'b0, nz_q};
  wire        take  = acc_req && acc_ack;

  assign busy      = st != S_IDLE;
  assign done      = done_q;
  assign err       = err_q;
  assign acc_req   = st != S_IDLE;
  assign acc_we    = st == S_WR;
  assign acc_win   = win_q;
  assign acc_dev   = dev_q;
  assign acc_off   = (st == S_CAP) ? CAP_OFF : ZONE_OFF + (OFF_W'(zone_q) << 4);
  assign acc_wdata = big_endian ? swap32(word_q) : word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; on_q <= 1'b0; whole_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      win_q <= '0; dev_q <= '0; zone_q <= '0; nz_q <= '0; word_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (!known) begin
            done_q <= 1'b1; err_q <= 1'b1;
          end else begin
            on_q <= req_on; whole_q <= l_whole;
            win_q <= l_win; dev_q <= l_dev;
            zone_q <= '0; nz_q <= 8'd1;
            st <= (req_on && l_whole) ? S_CAP : S_RD;
          end
        end
        S_CAP: if (take) begin
          if (acc_err) begin
            st <= S_IDLE; done_q <= 1'b1; err_q <= 1'b1;
          end else if (rd[7:0] == 8'd0) begin
            st <= S_IDLE; done_q <= 1'b1;
          end else begin
            nz_q <= rd[7:0]; st <= S_RD;
          end
        end
        S_RD: if (take) begin
          if (acc_err) begin
            st <= S_IDLE; done_q <= 1'b1; err_q <= 1'b1;
          end else if (on_q) begin
            if (rd[B_ONS]) begin
              if (zlast) begin st <= S_IDLE; done_q <= 1'b1; end
              else zone_q <= znext[7:0];
            end else begin
              word_q <= (rd & ~(32'd1 << B_DN)) | ON_SET;
              st <= S_WR;
            end
          end else if (whole_q) begin
            if (rd[B_OFFS]) begin st <= S_IDLE; done_q <= 1'b1; end
            else begin word_q <= 32'd1 << B_DN; st <= S_WR; end
          end else begin
            word_q <= (rd | (32'd1 << B_DN)) & ~(32'd1 << B_UP);
            st <= S_WR;
          end
        end
        S_WR: if (take) begin
          if (acc_err) begin
            st <= S_IDLE; done_q <= 1'b1; err_q <= 1'b1;
          end else if (zlast) begin
            st <= S_IDLE; done_q <= 1'b1;
          end else begin
            zone_q <= znext[7:0]; st <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !busy && !done);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_ack |=> acc_req && $stable(acc_off) && $stable(acc_dev) && $stable(acc_we));
  p_on_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we && on_q |-> word_q[B_UP] && !word_q[B_DN] && word_q[B_RST]);
  p_off_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we && !on_q |-> word_q[B_DN] && !word_q[B_UP]);
  p_unknown_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy && !known |=> done && err && !acc_req);
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n) err |-> done);
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take && acc_err |=> !acc_req && done);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !acc_req);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
endmodule

// File: tb/tb_pwr_dom_seq.sv
module tb_pwr_dom_seq;
  localparam int CLK_P = 10;
  localparam int NV = 8;

  logic clk = 0, rst_n = 0, big_endian = 0, req_valid = 0, req_on = 0;
  logic [2:0] req_dom = 0;
  logic busy, done, err, acc_req, acc_we, acc_ack = 0, acc_err = 0;
  logic [7:0] acc_win, acc_dev;
  logic [15:0] acc_off;
  logic [31:0] acc_wdata, acc_rdata = 0;

  pwr_dom_seq dut (.clk, .rst_n, .big_endian, .req_valid, .req_on, .req_dom,
    .busy, .done, .err, .acc_req, .acc_we, .acc_win, .acc_dev, .acc_off,
    .acc_wdata, .acc_ack, .acc_rdata, .acc_err);

  always #(CLK_P/2) clk = ~clk;

  // remote model
  logic [31:0] mem [0:79];
  int acc_cnt = 0, rd_cnt = 0, wr_cnt = 0, bad_cnt = 0, err_at = 0;
  logic [7:0] exp_win = 0, exp_dev = 0;
  logic [16:0] logv [0:31];
  logic pl_en = 0; int pl_idx = 0; logic [31:0] pl_val = 0;

  function automatic int midx(input logic [7:0] dv, input logic [15:0] off);
    int s;
    case (dv) 8'd2: s = 0; 8'd14: s = 1; 8'd15: s = 2; 8'd17: s = 3; default: s = 4; endcase
    return s * 16 + int'(off[7:4]);
  endfunction
  function automatic logic [31:0] sw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  always @(posedge clk) begin
    if (pl_en) mem[pl_idx] <= pl_val;
    if (acc_req && !acc_ack) begin
      acc_ack <= 1;
      acc_err <= (acc_cnt + 1 == err_at);
      acc_cnt <= acc_cnt + 1;
      logv[acc_cnt % 32] <= {acc_we, acc_off};
      if (acc_win != exp_win || acc_dev != exp_dev) bad_cnt <= bad_cnt + 1;
      if (acc_we) begin
        wr_cnt <= wr_cnt + 1;
        if (acc_cnt + 1 != err_at)
          mem[midx(acc_dev, acc_off)] <= big_endian ? sw(acc_wdata) : acc_wdata;
      end else begin
        rd_cnt <= rd_cnt + 1;
        acc_rdata <= big_endian ? sw(mem[midx(acc_dev, acc_off)]) : mem[midx(acc_dev, acc_off)];
      end
    end else begin
      acc_ack <= 0; acc_err <= 0;
    end
  end

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: actual %h expected %h", tag, act, exp); end
  endtask

  task automatic preload(input int idx, input logic [31:0] v);
    @(negedge clk); pl_en = 1; pl_idx = idx; pl_val = v;
    @(negedge clk); pl_en = 0;
  endtask

  task automatic set_target(input logic [2:0] d);
    case (d)
      3'd1: begin exp_win = 8'h20; exp_dev = 8'd14; end
      3'd2: begin exp_win = 8'h20; exp_dev = 8'd15; end
      3'd3: begin exp_win = 8'h00; exp_dev = 8'd2; end
      default: begin exp_win = 8'h20; exp_dev = 8'd17; end
    endcase
  endtask

  task automatic issue(input logic [2:0] d, input logic on);
    @(negedge clk); req_valid = 1; req_dom = d; req_on = on;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic wait_done(output logic e);
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(done, "R11 done timeout", {31'd0, done}, 1);
    e = err;
  endtask

  // dom, on, be, init, exp, writes
  localparam logic [70:0] VEC [NV] = '{
    {3'd1, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_1D00, 2'd1},
    {3'd2, 1'b1, 1'b0, 32'h0400_0200, 32'h0400_0200, 2'd0},
    {3'd3, 1'b1, 1'b1, 32'h0000_0201, 32'h0000_1D01, 2'd1},
    {3'd1, 1'b0, 1'b0, 32'h0000_1D00, 32'h0000_1B00, 2'd1},
    {3'd2, 1'b0, 1'b1, 32'h0200_0600, 32'h0200_0200, 2'd1},
    {3'd3, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FBFF, 2'd1},
    {3'd4, 1'b0, 1'b0, 32'h0000_1D00, 32'h0000_0200, 2'd1},
    {3'd4, 1'b0, 1'b1, 32'h0200_0000, 32'h0200_0000, 2'd0}
  };

  initial begin
    int wd = 0;
    forever begin
      @(negedge clk); wd++;
      if (wd > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected <150000", wd);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic e; int w0, r0, b0, a0;
    for (int i = 0; i < 80; i++) preload(i, 32'h0);
    @(negedge clk);
    chk(!busy && !done && !err && !acc_req, "R1 reset state", {28'd0, busy, done, err, acc_req}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] d; logic on, be; logic [31:0] ini, ex; logic [1:0] nw; int ix;
      {d, on, be, ini, ex, nw} = VEC[v];
      set_target(d);
      ix = midx(exp_dev, 16'h40);
      preload(ix, ini);
      big_endian = be;
      w0 = wr_cnt; b0 = bad_cnt;
      issue(d, on);
      wait_done(e);
      chk(!e, "R11 err low on success", {31'd0, e}, 0);
      chk(mem[ix] == ex, on ? "R3/R7 zone on word" : "R4/R5 off word", mem[ix], ex);
      chk(wr_cnt - w0 == int'(nw), "R3 R5 write count", wr_cnt - w0, {30'd0, nw});
      chk(bad_cnt == b0, "R2 window/device", bad_cnt - b0, 0);
      @(negedge clk);
      chk(!done, "R11 single pulse", {31'd0, done}, 0);
    end

    // R6 whole-device on, 3 zones, middle already on
    big_endian = 0; set_target(3'd4);
    preload(48, 32'd3); preload(52, 32'h0); preload(53, 32'h0400_0000); preload(54, 32'h0000_0200);
    r0 = rd_cnt; w0 = wr_cnt; a0 = acc_cnt;
    issue(3'd4, 1);
    wait_done(e);
    chk(!e && mem[52] == 32'h1D00 && mem[53] == 32'h0400_0000 && mem[54] == 32'h1D00,
        "R6 zone words", mem[54], 32'h1D00);
    chk(rd_cnt - r0 == 4 && wr_cnt - w0 == 2, "R6 access counts", rd_cnt - r0, 4);
    chk(logv[a0 % 32] == 17'h00004 && logv[(a0 + 5) % 32] == 17'h10060,
        "R6 order cap first, last write zone 2", {15'd0, logv[(a0 + 5) % 32]}, 32'h10060);

    // R6 zero zones
    preload(48, 32'd0); preload(52, 32'h0);
    r0 = rd_cnt; w0 = wr_cnt;
    issue(3'd4, 1);
    wait_done(e);
    chk(!e && rd_cnt - r0 == 1 && wr_cnt - w0 == 0, "R6 zero zones", wr_cnt - w0, 0);

    // R7 big-endian capability
    big_endian = 1;
    preload(48, 32'd2); preload(52, 32'h0); preload(53, 32'h0);
    issue(3'd4, 1);
    wait_done(e);
    chk(mem[53] == 32'h1D00, "R7 swapped count", mem[53], 32'h1D00);
    big_endian = 0;

    // R8 unknown domains
    for (int k = 0; k < 2; k++) begin
      a0 = acc_cnt;
      @(negedge clk); req_valid = 1; req_dom = (k == 0) ? 3'd5 : 3'd0; req_on = 1;
      @(negedge clk); req_valid = 0;
      chk(done && err, "R8 unknown id done+err", {30'd0, done, err}, 3);
      chk(acc_cnt == a0 && !busy, "R8 no access", acc_cnt - a0, 0);
    end

    // R9 error on third access
    preload(48, 32'd3); preload(52, 32'h0); preload(53, 32'h0);
    a0 = acc_cnt; err_at = acc_cnt + 3;
    issue(3'd4, 1);
    wait_done(e);
    chk(e, "R9 error reported", {31'd0, e}, 1);
    chk(acc_cnt - a0 == 3 && mem[52] == 0 && mem[53] == 0, "R9 abort", acc_cnt - a0, 3);
    err_at = 0;

    // R10 busy ignores second request
    set_target(3'd1);
    preload(midx(8'd2, 16'h40), 32'h0000_1234); preload(midx(8'd14, 16'h40), 32'h0);
    @(negedge clk); req_valid = 1; req_dom = 3'd1; req_on = 1;
    @(negedge clk); req_dom = 3'd3; req_on = 0;
    chk(busy, "R10 busy after accept", {31'd0, busy}, 1);
    @(negedge clk); req_valid = 0;
    wait_done(e);
    chk(!busy, "R10 busy low at done", {31'd0, busy}, 0);
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (done) chk(0, "R10 extra done", 1, 0); end
    chk(mem[midx(8'd2, 16'h40)] == 32'h1234, "R10 ignored request", mem[midx(8'd2, 16'h40)], 32'h1234);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule